// File: doc/BRIEF.md
# Shift-Register Noise Source With Divider

This block produces a pseudo-random noise bit from a 24-stage shift register that moves one step on each cycle where the shift enable is high. The two register stages at positions 10 and 23 are combined by an exclusive-OR. That XOR result is the noise output. Its complement is loaded into stage 0 while every other stage moves up by one place. The noise is therefore taken ahead of the register and not from one of its stages.

A small up counter counts the rising edges of the noise bit. It is clocked in the same domain, and a registered copy of the noise bit finds the edges. A build-time parameter picks one of two counter variants. The eight-state variant gives one output that is high in the upper half of its count. The sixteen-state variant brings out counter bits 2 and 1 as two separate lower-rate noise signals. A synchronous clear input, normally driven by a sound-enable line, holds the counter at zero.

Top module: `lfsr_noise_div`

## Requirements
- R1: While rst_n is low at a clock edge, all shift-register stages, the edge-detect copy and the counter go to zero, so noise_o and div_o read 0 after that edge.
- R2: noise_o always equals the XOR of shift-register stage 10 and stage 23, with no register between those stages and the port.
- R3: On a clock edge with shift_en high, every stage n moves to stage n+1 and stage 0 receives the inverse of noise_o as it was before the edge.
- R4: On a clock edge with shift_en low, the shift register holds its value, so noise_o does not change.
- R5: The counter rises by one on the clock edge at which noise_o is 1 and was 0 at the previous edge, so it lags the noise rise by one cycle. On every other edge it holds its value.
- R6: When cnt_clr is high at a clock edge, the counter is 0 after that edge. This overrides an increment and leaves the shift register untouched.
- R7: With VARIANT = 0 the counter steps 0 to 7 and wraps from 7 to 0. div_o[0] is 1 exactly when the count is 4 or more, and div_o[1] is always 0.
- R8: With VARIANT = 1 the counter steps 0 to 15 and wraps from 15 to 0. div_o[1] is counter bit 2 and div_o[0] is counter bit 1.
- R9: Starting from reset, noise_o stays 0 through the first ten shifts and becomes 1 after the eleventh, because ones fill stages 0 to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advances the shift register by one stage on this edge |
| cnt_clr | input | 1 | Synchronous clear of the edge counter, active high |
| noise_o | output | 1 | Raw noise bit: XOR of stages 10 and 23 |
| div_o | output | 2 | Divided noise outputs, coded by the VARIANT parameter |

## Verification
A wrong shift-register stage appears on noise_o within at most 24 shifts, because every stage reaches tap 23. Most errors show far sooner through tap 10. The bench follows the full sequence for several thousand shifts, so any error in feedback polarity or tap position breaks the comparison early. An edge-detect or counter fault shows on div_o one cycle after the noise rise in question. A missed wrap shows after at most eight or sixteen rises, depending on the variant. Both variants run side by side on the same stimulus.

// File: rtl/lfsr_noise_div_pkg.sv
// Package: shared constants and helpers for the noise source with divider.
// Assumes: VARIANT is 0 (eight-state count) or 1 (sixteen-state count).
package lfsr_noise_div_pkg;

    typedef enum logic {
        DIV_HALF_OF_EIGHT = 1'b0,
        DIV_BITS_OF_SIXTEEN = 1'b1
    } div_variant_e;

    // Highest count value before the counter wraps, per variant.
    function automatic int wrap_value(input int variant);
        return (variant == 0) ? 7 : 15;
    endfunction

endpackage

// File: rtl/lfsr_noise_shreg.sv
// Module: shift register with XOR taps. Produces the raw noise bit ahead of
// the register and loads its complement into stage 0 on each enabled edge.
// Assumes: TAP_A and TAP_B are below LEN; reset is synchronous, active low.
module lfsr_noise_shreg #(
    parameter int LEN   = 24,
    parameter int TAP_A = 10,
    parameter int TAP_B = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic noise
);

    logic [LEN-1:0] stages;

    // Noise bit: exclusive-OR of the two tapped stages.
    assign noise = stages[TAP_A] ^ stages[TAP_B];

    // Shift up by one stage; stage 0 takes the inverted XOR result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else if (adv) begin
            stages <= {stages[LEN-2:0], ~noise};
        end
    end

endmodule

// File: rtl/lfsr_noise_rise.sv
// Module: rising-edge detector for a signal in the clk domain.
// Assumes: d is synchronous to clk; the registered copy resets to 0.
module lfsr_noise_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);

    logic d_q;

    // Keep the value d had at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= 1'b0;
        end else begin
            d_q <= d;
        end
    end

    // Rise: high now, low at the previous edge.
    assign rise = d & ~d_q;

endmodule

// File: rtl/lfsr_noise_count.sv
// Module: wrapping up counter with synchronous clear taking priority.
// Assumes: WRAP fits in CNT_W bits.
module lfsr_noise_count #(
    parameter int CNT_W = 4,
    parameter int WRAP  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP);

    // Count up on inc and wrap to zero after WRAP; clear wins over inc.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == WRAP_V) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lfsr_noise_div.sv
// Module: top of the noise source with divider. Links the shift register,
// the edge detector and the edge counter, and decodes the divided outputs
// for the variant selected at build time.
// Assumes: VARIANT 0 or 1; CNT_W of at least 3; single clock domain.
module lfsr_noise_div
    import lfsr_noise_div_pkg::*;
#(
    parameter int SR_LEN  = 24,
    parameter int TAP_A   = 10,
    parameter int TAP_B   = 23,
    parameter int CNT_W   = 4,
    parameter int VARIANT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       cnt_clr,
    output logic       noise_o,
    output logic [1:0] div_o
);

    localparam int WRAP = wrap_value(VARIANT);
    localparam int HALF = (WRAP + 1) / 2;

    logic             noise_rise;
    logic [CNT_W-1:0] edge_cnt;

    lfsr_noise_shreg #(
        .LEN   (SR_LEN),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B)
    ) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .noise (noise_o)
    );

    lfsr_noise_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (noise_o),
        .rise  (noise_rise)
    );

    lfsr_noise_count #(
        .CNT_W (CNT_W),
        .WRAP  (WRAP)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (noise_rise),
        .cnt   (edge_cnt)
    );

    // Output decode chosen by the variant parameter.
    generate
        if (VARIANT == int'(DIV_HALF_OF_EIGHT)) begin : g_half
            // Single output: high in the upper half of the count.
            assign div_o = {1'b0, (edge_cnt >= CNT_W'(HALF))};
        end else begin : g_bits
            // Two outputs: counter bits 2 and 1.
            assign div_o = {edge_cnt[2], edge_cnt[1]};
        end
    endgenerate

endmodule

// File: rtl/lfsr_noise_div_chk.sv
// Module: property checker for lfsr_noise_div, attached with bind.
// Assumes: observes only the ports of the top module.
module lfsr_noise_div_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shift_en,
    input logic       cnt_clr,
    input logic       noise_o,
    input logic [1:0] div_o
);

    logic noise_d;

    // Checker's own copy of the previous noise value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise_d <= 1'b0;
        end else begin
            noise_d <= noise_o;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (noise_o == 1'b0 && div_o == 2'b00)); // R1

    AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(noise_o)); // R4

    AST_COUNT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !(noise_o && !noise_d)) |=> $stable(div_o)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (div_o == 2'b00)); // R6

endmodule

bind lfsr_noise_div lfsr_noise_div_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .cnt_clr  (cnt_clr),
    .noise_o  (noise_o),
    .div_o    (div_o)
);

// File: tb/lfsr_noise_div_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver task computes the expected outputs from the
// requirements and queues them. The monitor pops and compares after each edge.
module lfsr_noise_div_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       cnt_clr = 1'b0;
    logic       noise16, noise8;
    logic [1:0] div16, div8;

    int n_checks = 0;
    int n_fail = 0;
    int wraps8 = 0;
    int wraps16 = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lfsr_noise_div #(.VARIANT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cnt_clr(cnt_clr),
        .noise_o(noise16), .div_o(div16)
    );

    lfsr_noise_div #(.VARIANT(0)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cnt_clr(cnt_clr),
        .noise_o(noise8), .div_o(div8)
    );

    typedef struct packed {
        logic       noise;
        logic [1:0] d16;
        logic [1:0] d8;
    } exp_t;

    exp_t       sb[$];
    logic [23:0] m_sr = '0;
    logic        m_prev = 1'b0;
    int          m_c8 = 0;
    int          m_c16 = 0;

    function automatic logic m_noise(input logic [23:0] s);
        return s[10] ^ s[23]; // R2
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the model's outputs.
    task automatic step(input bit sh, input bit clr);
        logic nz, rise;
        @(negedge clk);
        shift_en = sh;
        cnt_clr = clr;
        nz = m_noise(m_sr);
        rise = nz & ~m_prev;            // R5
        m_prev = nz;
        if (clr) begin                  // R6
            m_c8 = 0;
            m_c16 = 0;
        end else if (rise) begin
            if (m_c8 == 7) begin m_c8 = 0; wraps8++; end else m_c8++;       // R7
            if (m_c16 == 15) begin m_c16 = 0; wraps16++; end else m_c16++;  // R8
        end
        if (sh) m_sr = {m_sr[22:0], ~nz}; // R3, R4 hold otherwise
        sb.push_back('{noise: m_noise(m_sr),
                       d16: {m_c16[2], m_c16[1]},
                       d8: {1'b0, (m_c8 >= 4)}});
    endtask

    // Monitor: compare just after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(noise16 == e.noise, "R2/R3/R4/R9 noise", int'(noise16), int'(e.noise));
            check(noise8 == e.noise, "R2/R3/R6 noise var0", int'(noise8), int'(e.noise));
            check(div16 == e.d16, "R5/R6/R8 div var1", int'(div16), int'(e.d16));
            check(div8 == e.d8, "R5/R6/R7 div var0", int'(div8), int'(e.d8));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check(noise16 == 1'b0 && noise8 == 1'b0, "R1 noise after reset", int'(noise16), 0);
        check(div16 == 2'b00 && div8 == 2'b00, "R1 div after reset", int'(div16), 0);
        rst_n = 1'b1;
        // R9: ten shifts keep noise low, the eleventh raises it
        for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check(noise16 == 1'b1, "R9 noise after eleven shifts", int'(noise16), 1);
        // R4: idle cycles hold the register
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        // Mixed pattern: gaps in shifting, clear bursts (R6), long runs for wraps
        for (int i = 0; i < 6000; i++) begin
            step((i % 5) != 3, (i % 397) < 3);
        end
        // R6 during a rise: clear held while shifting
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        @(negedge clk);
        check(wraps8 > 0, "R7 wrap reached", wraps8, 1);
        check(wraps16 > 0, "R8 wrap reached", wraps16, 1);
        check(sb.size() == 0, "R5 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule